// File: doc/BRIEF.md
# Age-Ordered Redirect Filter

This block sits between the back-end units that ask for a pipeline flush and the pipeline stages that carry one out. Each cycle, up to `N_SRC` request sources can each present a redirect. A redirect carries a thread number, the sequence number of the instruction that caused it, a mispredict flag, a corrected target address and a taken bit. For every thread, the filter keeps a bound: the sequence number of the youngest instruction still valid in the reorder window. A request is passed on only if it is strictly older than that bound. A request from an instruction at or beyond the bound comes from work that has already been flushed, so the filter drops it.

Among the surviving requests for one thread, the oldest one wins. Its payload is registered and broadcast on that thread's output lane for one cycle, and the thread's bound drops to the winner's sequence number. The bound rises again when the reorder window inserts a new instruction for that thread. A running counter records how many redirects have been accepted. The threads are filtered independently, so several lanes can broadcast in the same cycle.

Top module: `rf_redirect_filter`

## Requirements
- R1: After reset, every thread bound holds the all-ones sequence value, no lane broadcasts, and the accepted-redirect counter reads zero.
- R2: A request for thread t is accepted only when its sequence number is strictly smaller than thread t's bound. A request equal to or larger than the bound is dropped. In particular, a request carrying the all-ones value is dropped even straight after reset.
- R3: When thread t accepts a redirect, its bound becomes the accepted sequence number.
- R4: When several surviving requests target the same thread in one cycle, the smallest sequence number wins. If two winners tie, the request on the lowest source index wins.
- R5: The broadcast on lane t carries the winner's sequence number, mispredict flag, target address and taken bit, unchanged.
- R6: The broadcast is registered. `bc_vld[t]` is high in the cycle after the request is sampled, and it stays high only while accepted requests keep arriving for thread t.
- R7: Threads are filtered independently. Requests for different threads in the same cycle can each be accepted, and each lands on its own lane.
- R8: An insert for thread t (`ins_vld`, `ins_tid`, `ins_seq`) sets thread t's bound to `ins_seq`. If thread t also accepts a redirect in that cycle, the redirect's sequence number is what the bound takes.
- R9: `squash_cnt` grows by the number of lanes that accept a redirect in a cycle, and it wraps modulo 2^CNT_W.
- R10: A dropped request has no effect: no lane broadcasts it and the bound stays where it was. The bench observes this through the acceptance of later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_vld | input | N_SRC | Request present, one bit per source |
| src_tid | input | N_SRC*TID_W | Thread number for each source |
| src_seq | input | N_SRC*SEQ_W | Sequence number of the causing instruction, per source |
| src_mispred | input | N_SRC | Mispredict flag, per source |
| src_target | input | N_SRC*ADDR_W | Corrected target address, per source |
| src_taken | input | N_SRC | Taken bit, per source |
| ins_vld | input | 1 | An instruction enters the reorder window this cycle |
| ins_tid | input | TID_W | Thread of the inserted instruction |
| ins_seq | input | SEQ_W | Sequence number of the inserted instruction |
| bc_vld | output | N_THR | Broadcast valid, one lane per thread |
| bc_seq | output | N_THR*SEQ_W | Squash-back-to sequence number, per lane |
| bc_mispred | output | N_THR | Mispredict flag, per lane |
| bc_target | output | N_THR*ADDR_W | Corrected target, per lane |
| bc_taken | output | N_THR | Taken bit, per lane |
| squash_cnt | output | CNT_W | Running count of accepted redirects |

## Verification
The checker runs on every cycle and tests four things:
- every broadcast sequence is below the bound that was in force one cycle earlier;
- the bound equals the sequence just broadcast;
- no lane fires without a request for its thread in the cycle before;
- the counter advances exactly by the number of active lanes.

Some behaviours are only visible in the bench scenarios, which compare against a behavioural model every clock:
- which of several same-thread requests wins, including the equal-sequence tie;
- that the payload fields come from that winner;
- that inserts raise the bound;
- that dropped requests leave no trace.

// File: rtl/rf_pkg.sv
package rf_pkg;

    // Which event chose a thread bound's next value.
    typedef enum logic [1:0] {
        BND_HOLD   = 2'd0,
        BND_SQUASH = 2'd1,
        BND_INSERT = 2'd2
    } bnd_src_e;

    // Width of an index over n items, at least one bit.
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/rf_oldest_pick.sv
module rf_oldest_pick #(
    parameter int N_SRC  = 3,
    parameter int SEQ_W  = 16,
    parameter int TID_W  = 1,
    parameter int THR_ID = 0,
    localparam int IDX_W = rf_pkg::idx_width(N_SRC)
) (
    input  logic [N_SRC-1:0]       src_vld,
    input  logic [N_SRC*TID_W-1:0] src_tid,
    input  logic [N_SRC*SEQ_W-1:0] src_seq,
    input  logic [SEQ_W-1:0]       bound,
    output logic                   hit,
    output logic [IDX_W-1:0]       win_idx,
    output logic [SEQ_W-1:0]       win_seq
);

    // Per-source qualification: request for this thread and strictly older.
    logic [N_SRC-1:0] elig;

    for (genvar s = 0; s < N_SRC; s++) begin : g_elig
        assign elig[s] = src_vld[s]
                       && (src_tid[s*TID_W +: TID_W] == TID_W'(THR_ID))
                       && (src_seq[s*SEQ_W +: SEQ_W] < bound);
    end

    // Oldest eligible request; a strict compare keeps the lowest index on ties.
    always_comb begin
        hit     = 1'b0;
        win_idx = '0;
        win_seq = '0;
        for (int s = 0; s < N_SRC; s++) begin
            if (elig[s] && (!hit || (src_seq[s*SEQ_W +: SEQ_W] < win_seq))) begin
                hit     = 1'b1;
                win_idx = IDX_W'(s);
                win_seq = src_seq[s*SEQ_W +: SEQ_W];
            end
        end
    end

endmodule

// File: rtl/rf_bound_reg.sv
module rf_bound_reg #(
    parameter int SEQ_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sq_hit,
    input  logic [SEQ_W-1:0] sq_seq,
    input  logic             ins_hit,
    input  logic [SEQ_W-1:0] ins_seq,
    output logic [SEQ_W-1:0] bound_q,
    output rf_pkg::bnd_src_e upd_src
);

    typedef struct packed {
        logic [SEQ_W-1:0] bound;
    } bnd_state_t;

    bnd_state_t st_d, st_q;

    // Next value: an accepted squash outranks an insert in the same cycle.
    always_comb begin
        st_d    = st_q;
        upd_src = rf_pkg::BND_HOLD;
        if (sq_hit) begin
            st_d.bound = sq_seq;
            upd_src    = rf_pkg::BND_SQUASH;
        end else if (ins_hit) begin
            st_d.bound = ins_seq;
            upd_src    = rf_pkg::BND_INSERT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.bound <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign bound_q = st_q.bound;

endmodule

// File: rtl/rf_redirect_filter.sv
module rf_redirect_filter #(
    parameter int N_THR  = 2,
    parameter int N_SRC  = 3,
    parameter int SEQ_W  = 16,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    localparam int TID_W = rf_pkg::idx_width(N_THR),
    localparam int IDX_W = rf_pkg::idx_width(N_SRC)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_SRC-1:0]        src_vld,
    input  logic [N_SRC*TID_W-1:0]  src_tid,
    input  logic [N_SRC*SEQ_W-1:0]  src_seq,
    input  logic [N_SRC-1:0]        src_mispred,
    input  logic [N_SRC*ADDR_W-1:0] src_target,
    input  logic [N_SRC-1:0]        src_taken,
    input  logic                    ins_vld,
    input  logic [TID_W-1:0]        ins_tid,
    input  logic [SEQ_W-1:0]        ins_seq,
    output logic [N_THR-1:0]        bc_vld,
    output logic [N_THR*SEQ_W-1:0]  bc_seq,
    output logic [N_THR-1:0]        bc_mispred,
    output logic [N_THR*ADDR_W-1:0] bc_target,
    output logic [N_THR-1:0]        bc_taken,
    output logic [CNT_W-1:0]        squash_cnt
);

    localparam int CW = rf_pkg::idx_width(N_THR + 1);

    typedef struct packed {
        logic              vld;
        logic [SEQ_W-1:0]  seq;
        logic              mp;
        logic [ADDR_W-1:0] tgt;
        logic              tk;
    } lane_t;

    typedef struct packed {
        lane_t [N_THR-1:0] lane;
        logic [CNT_W-1:0]  cnt;
    } flt_state_t;

    flt_state_t st_d, st_q;

    logic [N_THR-1:0]             thr_hit;
    logic [IDX_W-1:0]             thr_idx [N_THR];
    logic [SEQ_W-1:0]             thr_seq [N_THR];
    logic [N_THR*SEQ_W-1:0]       bound_flat;
    rf_pkg::bnd_src_e             thr_upd [N_THR];

    // Per-thread arbitration and bound tracking.
    for (genvar t = 0; t < N_THR; t++) begin : g_thr
        logic ins_here;
        assign ins_here = ins_vld && (ins_tid == TID_W'(t));

        rf_oldest_pick #(
            .N_SRC (N_SRC),
            .SEQ_W (SEQ_W),
            .TID_W (TID_W),
            .THR_ID(t)
        ) u_pick (
            .src_vld(src_vld),
            .src_tid(src_tid),
            .src_seq(src_seq),
            .bound  (bound_flat[t*SEQ_W +: SEQ_W]),
            .hit    (thr_hit[t]),
            .win_idx(thr_idx[t]),
            .win_seq(thr_seq[t])
        );

        rf_bound_reg #(
            .SEQ_W(SEQ_W)
        ) u_bound (
            .clk    (clk),
            .rst_n  (rst_n),
            .sq_hit (thr_hit[t]),
            .sq_seq (thr_seq[t]),
            .ins_hit(ins_here),
            .ins_seq(ins_seq),
            .bound_q(bound_flat[t*SEQ_W +: SEQ_W]),
            .upd_src(thr_upd[t])
        );
    end

    // Broadcast lanes and acceptance counter, next values.
    always_comb begin
        logic [CW-1:0] n_acc;
        st_d  = st_q;
        n_acc = '0;
        for (int t = 0; t < N_THR; t++) begin
            st_d.lane[t].vld = thr_hit[t];
            if (thr_hit[t]) begin
                st_d.lane[t].seq = thr_seq[t];
                st_d.lane[t].mp  = src_mispred[thr_idx[t]];
                st_d.lane[t].tgt = src_target[thr_idx[t]*ADDR_W +: ADDR_W];
                st_d.lane[t].tk  = src_taken[thr_idx[t]];
                n_acc            = n_acc + CW'(1);
            end
        end
        st_d.cnt = st_q.cnt + CNT_W'(n_acc);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar t = 0; t < N_THR; t++) begin : g_out
        assign bc_vld[t]                      = st_q.lane[t].vld;
        assign bc_seq[t*SEQ_W +: SEQ_W]       = st_q.lane[t].seq;
        assign bc_mispred[t]                  = st_q.lane[t].mp;
        assign bc_target[t*ADDR_W +: ADDR_W]  = st_q.lane[t].tgt;
        assign bc_taken[t]                    = st_q.lane[t].tk;
    end

    assign squash_cnt = st_q.cnt;

endmodule

// File: rtl/rf_filter_chk.sv
module rf_filter_chk #(
    parameter int N_THR  = 2,
    parameter int N_SRC  = 3,
    parameter int SEQ_W  = 16,
    parameter int CNT_W  = 16,
    parameter int TID_W  = 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [N_SRC-1:0]       src_vld,
    input logic [N_SRC*TID_W-1:0] src_tid,
    input logic [N_THR-1:0]       bc_vld,
    input logic [N_THR*SEQ_W-1:0] bc_seq,
    input logic [CNT_W-1:0]       squash_cnt,
    input logic [N_THR*SEQ_W-1:0] bound_flat
);

    logic [N_THR-1:0] req_any;

    always_comb begin
        req_any = '0;
        for (int s = 0; s < N_SRC; s++) begin
            for (int t = 0; t < N_THR; t++) begin
                if (src_vld[s] && (src_tid[s*TID_W +: TID_W] == TID_W'(t)))
                    req_any[t] = 1'b1;
            end
        end
    end

    for (genvar t = 0; t < N_THR; t++) begin : g_lane
        // R2
        accept_below_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            bc_vld[t] |-> (bc_seq[t*SEQ_W +: SEQ_W] < $past(bound_flat[t*SEQ_W +: SEQ_W])));

        // R3
        bound_tracks_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
            bc_vld[t] |-> (bound_flat[t*SEQ_W +: SEQ_W] == bc_seq[t*SEQ_W +: SEQ_W]));

        // R6
        lane_needs_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
            bc_vld[t] |-> $past(req_any[t]));
    end

    // R9
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        squash_cnt == CNT_W'($past(squash_cnt) + CNT_W'($countones(bc_vld))));

endmodule

bind rf_redirect_filter rf_filter_chk #(
    .N_THR(N_THR),
    .N_SRC(N_SRC),
    .SEQ_W(SEQ_W),
    .CNT_W(CNT_W),
    .TID_W(TID_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_vld   (src_vld),
    .src_tid   (src_tid),
    .bc_vld    (bc_vld),
    .bc_seq    (bc_seq),
    .squash_cnt(squash_cnt),
    .bound_flat(bound_flat)
);

// File: tb/test_rf_redirect_filter.sv
`timescale 1ns/1ps
module test_rf_redirect_filter;

    localparam int NT = 2, NS = 3, SW = 16, AW = 32, CW = 16, TW = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    // Bench-side stimulus, unpacked per source.
    logic       s_v [NS];
    int         s_tid [NS];
    int         s_seq [NS];
    logic       s_mp [NS];
    logic [31:0] s_tgt [NS];
    logic       s_tk [NS];
    logic       i_v;
    int         i_tid, i_seq;

    logic [NS-1:0]    src_vld, src_mispred, src_taken;
    logic [NS*TW-1:0] src_tid;
    logic [NS*SW-1:0] src_seq;
    logic [NS*AW-1:0] src_target;
    logic [NT-1:0]    bc_vld, bc_mispred, bc_taken;
    logic [NT*SW-1:0] bc_seq;
    logic [NT*AW-1:0] bc_target;
    logic [CW-1:0]    squash_cnt;

    always_comb begin
        for (int s = 0; s < NS; s++) begin
            src_vld[s]               = s_v[s];
            src_tid[s*TW +: TW]      = TW'(s_tid[s]);
            src_seq[s*SW +: SW]      = SW'(s_seq[s]);
            src_mispred[s]           = s_mp[s];
            src_target[s*AW +: AW]   = s_tgt[s];
            src_taken[s]             = s_tk[s];
        end
    end

    rf_redirect_filter i_rf_redirect_filter (
        .clk(clk), .rst_n(rst_n),
        .src_vld(src_vld), .src_tid(src_tid), .src_seq(src_seq),
        .src_mispred(src_mispred), .src_target(src_target), .src_taken(src_taken),
        .ins_vld(i_v), .ins_tid(TW'(i_tid)), .ins_seq(SW'(i_seq)),
        .bc_vld(bc_vld), .bc_seq(bc_seq), .bc_mispred(bc_mispred),
        .bc_target(bc_target), .bc_taken(bc_taken), .squash_cnt(squash_cnt)
    );

    int checks = 0, bad = 0;
    string tag = "R1";

    // Reference model state.
    int m_bound [NT];
    int m_cnt;

    task automatic chk(input string req, input longint act, input longint exp, input string what);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_in();
        for (int s = 0; s < NS; s++) begin
            s_v[s] = 0; s_tid[s] = 0; s_seq[s] = 0; s_mp[s] = 0; s_tgt[s] = 0; s_tk[s] = 0;
        end
        i_v = 0; i_tid = 0; i_seq = 0;
    endtask

    task automatic req(input int s, input int tid, input int seq, input logic mp,
                       input logic [31:0] tgt, input logic tk);
        s_v[s] = 1; s_tid[s] = tid; s_seq[s] = seq; s_mp[s] = mp; s_tgt[s] = tgt; s_tk[s] = tk;
    endtask

    // Compute expectation, cross one edge, compare, update model.
    task automatic step();
        logic e_v [NT];
        int   e_seq [NT];
        logic e_mp [NT], e_tk [NT];
        logic [31:0] e_tgt [NT];
        for (int t = 0; t < NT; t++) begin
            int best = -1;
            for (int s = 0; s < NS; s++)
                if (s_v[s] && s_tid[s] == t && s_seq[s] < m_bound[t] &&
                    (best < 0 || s_seq[s] < s_seq[best])) best = s;
            e_v[t] = (best >= 0);
            e_seq[t] = 0; e_mp[t] = 0; e_tk[t] = 0; e_tgt[t] = 0;
            if (best >= 0) begin
                e_seq[t] = s_seq[best]; e_mp[t] = s_mp[best];
                e_tgt[t] = s_tgt[best]; e_tk[t] = s_tk[best];
                m_bound[t] = s_seq[best];
                m_cnt = (m_cnt + 1) % 65536;
            end else if (i_v && i_tid == t) begin
                m_bound[t] = i_seq;
            end
        end
        @(posedge clk);
        #1;
        for (int t = 0; t < NT; t++) begin
            chk(tag, bc_vld[t], e_v[t], $sformatf("lane%0d valid", t));
            if (e_v[t] && bc_vld[t]) begin
                chk(tag, bc_seq[t*SW +: SW], e_seq[t], $sformatf("lane%0d seq (R5)", t));
                chk(tag, bc_mispred[t], e_mp[t], $sformatf("lane%0d mispred (R5)", t));
                chk(tag, bc_target[t*AW +: AW], e_tgt[t], $sformatf("lane%0d target (R5)", t));
                chk(tag, bc_taken[t], e_tk[t], $sformatf("lane%0d taken (R5)", t));
            end
        end
        chk("R9", squash_cnt, m_cnt, "squash count");
        clear_in();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        clear_in();
        for (int t = 0; t < NT; t++) m_bound[t] = 65535;
        m_cnt = 0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state at the ports
        chk("R1", bc_vld, 0, "valid during reset");
        chk("R1", squash_cnt, 0, "count during reset");
        rst_n = 1;
        tag = "R1"; step();

        // R2: all-ones request dropped even after reset
        tag = "R2"; req(0, 0, 65535, 1, 32'hAAAA_0000, 1); step();
        // R1: max bound accepts the next-largest value
        tag = "R1"; req(0, 0, 65534, 1, 32'h1000_0004, 0); step();
        // R6: lane drops after one cycle
        tag = "R6"; step();
        // R8: insert raises bound
        tag = "R8"; i_v = 1; i_tid = 0; i_seq = 100; step();
        // R2: equal sequence dropped, one below accepted
        tag = "R2"; req(1, 0, 100, 0, 32'h2, 0); step();
        tag = "R3"; req(1, 0, 99, 0, 32'h3, 1); step();
        // R4: oldest wins, tie goes to lowest index
        tag = "R4"; req(0, 0, 50, 0, 32'h50, 0); req(1, 0, 30, 1, 32'h31, 1);
        req(2, 0, 30, 0, 32'h32, 0); step();
        // R10: stale request dropped, bound unchanged (29 still accepted)
        tag = "R10"; req(2, 0, 40, 1, 32'h40, 1); step();
        tag = "R10"; req(0, 0, 29, 1, 32'h29, 0); step();
        // R6: back-to-back accepts keep the lane valid
        tag = "R6"; req(0, 0, 20, 0, 32'h20, 1); step();
        tag = "R6"; req(0, 0, 10, 1, 32'h10, 0); step();
        // R7: both threads in one cycle
        tag = "R7"; req(0, 1, 500, 1, 32'h500, 1); req(1, 0, 5, 0, 32'h5, 1); step();
        // R8: redirect beats insert on the same thread
        tag = "R8"; i_v = 1; i_tid = 1; i_seq = 900; req(2, 1, 400, 0, 32'h400, 0); step();
        tag = "R8"; req(2, 1, 450, 0, 32'h450, 0); step();
        // Mixed traffic
        for (int n = 0; n < 400; n++) begin
            tag = "R4";
            for (int s = 0; s < NS; s++)
                if ($urandom_range(0, 2) == 0)
                    req(s, $urandom_range(0, NT-1), $urandom_range(0, 60), 1'($urandom),
                        $urandom, 1'($urandom));
            if ($urandom_range(0, 3) == 0) begin
                i_v = 1; i_tid = $urandom_range(0, NT-1); i_seq = $urandom_range(30, 80);
            end
            step();
        end
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule